// File: doc/BRIEF.md
# Sixth-Channel FM/PCM Output Selector

This block sits at the end of the sixth channel of a four-operator FM synthesizer. For each output slot of that channel it presents one signed 10-bit sample to the mixer. The sample is either the FM result from the existing operator pipeline or a raw 8-bit PCM value that software wrote. A one-bit source mode, held in its own control register, makes the choice. The FM pipeline is not reset or held when PCM is chosen. Only the output multiplexing changes, so the FM value that arrives at the next FM-mode slot is whatever the pipeline is producing at that moment.

The PCM byte is offset-binary. It is re-centred by subtracting 0x80 and scaled by four, which places it in the same 10-bit two's-complement range as the FM result. Register writes go through a small write port with a one-bit address. Address 0 is the PCM sample register. Address 1 is the mode register, of which only data bit 0 is used.

Internally a two-state machine tracks the presentation. In state SHOW the slot's sample is being presented with a valid strobe. In state IDLE the block is waiting between slots. Transitions: IDLE→SHOW on a slot strobe, SHOW→SHOW on a back-to-back slot strobe, SHOW→IDLE when no slot strobe arrives, and IDLE→IDLE otherwise.

Top module: `ch6_src_select`

## Requirements
- R1: After reset the mode is FM (a slot presents `fm_sample`), the PCM register holds 0x80 (PCM mode presents 0x000 before any sample write), `out_valid` is 0 and `out_sample` is 0x000.
- R2: `out_valid` is 1 in exactly the clock cycle after each cycle in which `slot_strobe` is 1, and 0 in every other cycle.
- R3: In FM mode, the sample presented after a slot equals the `fm_sample` value present in the slot cycle.
- R4: In PCM mode, the presented sample is (v − 0x80) × 4 as 10-bit two's complement: 0x00→0x200 (−512), 0x7F→0x3FC, 0x80→0x000, 0x81→0x004, 0xFF→0x1FC (+508).
- R5: A write to the PCM register (address 0) while in FM mode leaves the FM output unchanged. The stored byte is presented once PCM mode is selected.
- R6: A write in the same cycle as a slot strobe does not affect that slot's sample. It takes effect from the following slot.
- R7: Between slots `out_sample` holds its last presented value, whatever the inputs do.
- R8: A write to the mode register (address 1) sets PCM mode when data bit 0 is 1 and FM mode when it is 0. Data bits 7:1 are ignored.
- R9: In PCM mode, changes on `fm_sample` do not affect the output. Returning to FM mode presents the current `fm_sample` at the next slot, with no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 1 | 0: PCM sample register, 1: mode register |
| wr_data | input | 8 | Write data |
| slot_strobe | input | 1 | High for one cycle when the sixth channel's output slot occurs |
| fm_sample | input | 10 | Signed FM result of the sixth channel |
| out_sample | output | 10 | Signed sample presented to the mixer |
| out_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
FM pass-through is driven with alternating-bit and all-ones patterns, so that a swapped or dropped bit is caught. PCM conversion is driven at the two extremes, at the midpoint and at values one step either side of it. These separate a correct sign-bit inversion from an off-by-one offset or a missing ×4 scale. Directed cases write registers in a slot cycle, write in FM mode, set junk upper bits on the mode write and toggle the FM input during PCM mode. These show that the register, the slot timing and the source path each act independently.

// File: rtl/fmpcm_pkg.sv
package fmpcm_pkg;
    localparam int PCM_W = 8;
    localparam int SMP_W = 10;
    localparam logic [PCM_W-1:0] PCM_IDLE = 8'h80;

    localparam logic ADDR_PCM  = 1'b0;
    localparam logic ADDR_MODE = 1'b1;

    typedef enum logic {
        SEL_IDLE = 1'b0,
        SEL_SHOW = 1'b1
    } sel_state_t;
endpackage

// File: rtl/fmpcm_regs.sv
module fmpcm_regs #(
    parameter int PCM_W = 8,
    parameter logic [PCM_W-1:0] PCM_INIT = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [PCM_W-1:0] wr_data,
    output logic [PCM_W-1:0] pcm_q,
    output logic             pcm_mode_q
);
    import fmpcm_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcm_q      <= PCM_INIT;
            pcm_mode_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_PCM) pcm_q <= wr_data;
            else                     pcm_mode_q <= wr_data[0];
        end
    end

    // R8: mode follows data bit 0 of a mode write
    assert_mode_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_MODE) |=> (pcm_mode_q == $past(wr_data[0])));

    // R5: a sample write does not touch the mode
    assert_pcm_wr_keeps_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_PCM) |=> $stable(pcm_mode_q));
endmodule

// File: rtl/fmpcm_pcm_scale.sv
module fmpcm_pcm_scale #(
    parameter int PCM_W = 8,
    parameter int SMP_W = 10
) (
    input  logic [PCM_W-1:0] pcm_byte,
    output logic [SMP_W-1:0] pcm_signed
);
    localparam int SHIFT = SMP_W - PCM_W;

    // Offset-binary to two's complement: invert the top bit, then scale.
    generate
        if (SHIFT > 0) begin : g_scale
            assign pcm_signed = {~pcm_byte[PCM_W-1], pcm_byte[PCM_W-2:0], {SHIFT{1'b0}}};
        end else begin : g_trunc
            logic [PCM_W-1:0] centred;
            assign centred    = {~pcm_byte[PCM_W-1], pcm_byte[PCM_W-2:0]};
            assign pcm_signed = centred[PCM_W-1 -: SMP_W];
        end
    endgenerate

    initial assert (SMP_W >= 2 && PCM_W >= 2);
endmodule

// File: rtl/fmpcm_out_fsm.sv
module fmpcm_out_fsm #(
    parameter int SMP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_strobe,
    input  logic             pcm_mode,
    input  logic [SMP_W-1:0] fm_sample,
    input  logic [SMP_W-1:0] pcm_sample,
    output logic [SMP_W-1:0] out_sample,
    output logic             out_valid
);
    import fmpcm_pkg::*;

    sel_state_t state_q, state_d;
    logic [SMP_W-1:0] sample_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_IDLE: state_d = slot_strobe ? SEL_SHOW : SEL_IDLE;
            SEL_SHOW: state_d = slot_strobe ? SEL_SHOW : SEL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEL_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           sample_q <= '0;
        else if (slot_strobe) sample_q <= pcm_mode ? pcm_sample : fm_sample;
    end

    assign out_sample = sample_q;
    assign out_valid  = (state_q == SEL_SHOW);

    assert_valid_after_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_strobe |=> out_valid);
    assert_no_valid_without_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_strobe |=> !out_valid);
    assert_hold_between_slots_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_strobe |=> $stable(out_sample));
    assert_fm_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_strobe && !pcm_mode) |=> (out_sample == $past(fm_sample)));
    assert_pcm_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_strobe && pcm_mode) |=> (out_sample == $past(pcm_sample)));
endmodule

// File: rtl/ch6_src_select.sv
module ch6_src_select #(
    parameter int PCM_W = 8,
    parameter int SMP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [PCM_W-1:0] wr_data,
    input  logic             slot_strobe,
    input  logic [SMP_W-1:0] fm_sample,
    output logic [SMP_W-1:0] out_sample,
    output logic             out_valid
);
    logic [PCM_W-1:0] pcm_q;
    logic             pcm_mode_q;
    logic [SMP_W-1:0] pcm_signed;

    fmpcm_regs #(.PCM_W(PCM_W), .PCM_INIT(PCM_W'(1) << (PCM_W-1))) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pcm_q      (pcm_q),
        .pcm_mode_q (pcm_mode_q)
    );

    fmpcm_pcm_scale #(.PCM_W(PCM_W), .SMP_W(SMP_W)) u_scale (
        .pcm_byte   (pcm_q),
        .pcm_signed (pcm_signed)
    );

    fmpcm_out_fsm #(.SMP_W(SMP_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_strobe (slot_strobe),
        .pcm_mode    (pcm_mode_q),
        .fm_sample   (fm_sample),
        .pcm_sample  (pcm_signed),
        .out_sample  (out_sample),
        .out_valid   (out_valid)
    );

    // R6: a register write in the slot cycle does not alter the sample taken
    assert_same_cycle_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_strobe && wr_en && wr_addr == 1'b0 && $past(pcm_mode_q) && pcm_mode_q && rst_n)
        |=> (out_sample == $past(pcm_signed)));
endmodule

// File: tb/ch6_src_select_tb.sv
module ch6_src_select_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       slot_strobe = 1'b0;
    logic [9:0] fm_sample = 10'h000;
    logic [9:0] out_sample;
    logic       out_valid;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ch6_src_select u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .slot_strobe(slot_strobe), .fm_sample(fm_sample),
        .out_sample(out_sample), .out_valid(out_valid)
    );

    // {mode, pcm byte, fm sample, expected}
    localparam int NV = 8;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 8'h00, 10'h155, 10'h155},
        {1'b0, 8'hFF, 10'h3FF, 10'h3FF},
        {1'b1, 8'h00, 10'h2AA, 10'h200},
        {1'b1, 8'hFF, 10'h000, 10'h1FC},
        {1'b1, 8'h80, 10'h3FF, 10'h000},
        {1'b1, 8'h7F, 10'h155, 10'h3FC},
        {1'b1, 8'h81, 10'h0F0, 10'h004},
        {1'b1, 8'hC3, 10'h111, 10'h10C}
    };

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // pulse one slot; returns with the presented sample visible
    task automatic slot();
        slot_strobe = 1'b1;
        @(posedge clk); #1;
        slot_strobe = 1'b0;
        check("R2 valid after slot", {9'd0, out_valid}, 10'd1);
    endtask

    task automatic idle_cycle();
        @(posedge clk); #1;
        check("R2 valid low between slots", {9'd0, out_valid}, 10'd0);
    endtask

    initial begin
        #(200000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [9:0] held;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", {9'd0, out_valid}, 10'd0);
        check("R1 reset sample", out_sample, 10'h000);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: FM selected out of reset
        fm_sample = 10'h123;
        slot();
        check("R1 FM after reset", out_sample, 10'h123);
        idle_cycle();
        // R1: PCM register starts at silence
        reg_write(1'b1, 8'h01);
        slot();
        check("R1 PCM idle silence", out_sample, 10'h000);
        idle_cycle();

        // table walk: R3, R4
        for (int i = 0; i < NV; i++) begin
            reg_write(1'b1, {7'd0, VEC[i][28]});
            reg_write(1'b0, VEC[i][27:20]);
            fm_sample = VEC[i][19:10];
            slot();
            check(VEC[i][28] ? "R4 PCM scale" : "R3 FM pass", out_sample, VEC[i][9:0]);
            idle_cycle();
        end

        // R7: hold between slots while inputs move
        held = out_sample;
        fm_sample = 10'h2DD;
        reg_write(1'b0, 8'h11);
        reg_write(1'b1, 8'h00);
        idle_cycle();
        check("R7 hold", out_sample, held);

        // R5: sample write in FM mode invisible, then shown in PCM mode
        fm_sample = 10'h0AB;
        reg_write(1'b0, 8'h90);
        slot();
        check("R5 FM unaffected", out_sample, 10'h0AB);
        reg_write(1'b1, 8'h01);
        slot();
        check("R5 stored byte shown", out_sample, 10'h040);

        // R6: write in slot cycle applies from next slot
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'hA0;
        slot();
        wr_en = 1'b0;
        check("R6 old value kept", out_sample, 10'h040);
        slot();
        check("R6 new value next slot", out_sample, 10'h080);
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h00;
        slot();
        wr_en = 1'b0;
        check("R6 mode write same slot", out_sample, 10'h080);
        fm_sample = 10'h301;
        slot();
        check("R6 mode applies next slot", out_sample, 10'h301);

        // R8: upper bits of mode write ignored
        reg_write(1'b1, 8'hFE);
        fm_sample = 10'h0C7;
        slot();
        check("R8 0xFE keeps FM", out_sample, 10'h0C7);
        reg_write(1'b1, 8'h03);
        slot();
        check("R8 0x03 selects PCM", out_sample, 10'h080);

        // R9: FM input ignored in PCM mode, current FM shown on return
        fm_sample = 10'h3C3;
        slot();
        check("R9 FM ignored in PCM", out_sample, 10'h080);
        idle_cycle();
        fm_sample = 10'h1E1;
        reg_write(1'b1, 8'h00);
        slot();
        check("R9 FM resumes", out_sample, 10'h1E1);
        idle_cycle();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule